// File: doc/BRIEF.md
# Touch Sensor Burst Sequencer

This block is the control sequencer of a capacitive touch sensor. It watches the host's active-low select line and the serial clock line, and from them it decides when an acquisition burst starts, when the device sleeps and when it wakes. It drives the data-ready handshake back to the host as a value plus an output enable. The enable is low while the pin must float, and the tristate buffer sits outside the block. The burst itself is handled elsewhere: this block issues a one-cycle start pulse and waits for a one-cycle done pulse. Shifting the serial data and computing the position are also done elsewhere.

All intervals are counted in pulses of a one-microsecond tick input. Every interval is a parameter, so a simulation can shrink them.

The select line does three jobs. Holding it high lets bursts run freely at a fixed pace. A low pulse with no clocks inside it is a dummy command when its width falls within a window. After a transfer, a rising edge on it is the wake-and-burst trigger, but only once the device has gone to sleep.

Top module: `touch_burst_seq`

## Requirements
- R1: After reset, data-ready floats (enable 0) for T_PWR_FLOAT ticks. It is then driven low (enable 1, value 0) for T_CALIB ticks while calibration runs, and then driven high.
- R2: When idle with select held high (inactive), a burst starts after T_FREE_RUN ticks of continuous high select. The count restarts whenever select goes low and after each completed burst.
- R3: A select low pulse with no clock rising edge inside it, lasting T_DUMMY_MIN to T_DUMMY_MAX ticks inclusive, is a dummy command. On its rising edge data-ready stays driven high for T_SETTLE ticks, and then a burst starts.
- R4: A select low pulse with no clock edge that is shorter than T_DUMMY_MIN or longer than T_DUMMY_MAX ticks starts no burst. The block returns to idle with data-ready driven high.
- R5: A clock rising edge while select is low marks a transfer. T_QUIET ticks after the last clock rising edge, data-ready is driven low and the device sleeps. Select edges before that point are ignored.
- R6: While asleep, a rising edge on select wakes the device. Data-ready then floats for T_WAKE_FLOAT ticks, and a burst starts when the float ends. Float windows occur only on waking from sleep.
- R7: While asleep, a clock rising edge wakes the device and floats data-ready for T_WAKE_FLOAT ticks but starts no burst, unless select rises during the float. With no burst, data-ready is driven high and the device sleeps again after T_QUIET quiet ticks.
- R8: After T_DRIFT ticks asleep with no wake edge, the device wakes on its own, floats data-ready for T_WAKE_FLOAT ticks and runs a burst.
- R9: The burst start is a single-cycle pulse. Data-ready is driven low from the start of a burst until the done pulse arrives, and is driven high in the cycle after it.
- R10: Select and clock pass through two synchronising flip-flops before edge detection. The burst start pulse only occurs while data-ready is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| sel_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| burst_done | input | 1 | One-cycle pulse when the burst completes |
| burst_start | output | 1 | One-cycle pulse that starts a burst |
| rdy_out | output | 1 | Data-ready value |
| rdy_oe | output | 1 | Data-ready output enable, 0 means float |

## Verification
The bench builds the block with every interval scaled to a few ticks: power float 5, calibration 8, quiet 6, dummy window 3 to 12, settle 7, free-run 20, drift 40 and wake float 6. The tick comes every fourth clock. With these values, calibration, free-running bursts, accepted and rejected dummy pulses, sleep after a transfer, select and clock wakes, a select rising during a wake float, and the drift wake all fit into a few thousand cycles. A behavioural model follows each scenario on every clock.

// File: rtl/tsbs_pkg.sv
package tsbs_pkg;
  typedef enum logic [3:0] {
    ST_PFLOAT,
    ST_CAL,
    ST_IDLE,
    ST_SELECT,
    ST_TAIL,
    ST_SLEEP,
    ST_WAKE,
    ST_SETTLE,
    ST_BURST
  } seq_state_t;
endpackage

// File: rtl/tsbs_sync.sv
module tsbs_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[i]  = s2;
    assign rise[i] = s2 & ~s3;
    assign fall[i] = ~s2 & s3;
  end
endmodule

// File: rtl/tsbs_timer.sv
module tsbs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (tick && cnt != '1)
      cnt <= cnt + 1'b1;
  end

  // Saturation keeps an over-long select pulse from wrapping back into the dummy window.
  assert_timer_sat_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == '1) |=> (cnt == '1));
endmodule

// File: rtl/touch_burst_seq.sv
module touch_burst_seq
  import tsbs_pkg::*;
#(
  parameter int T_PWR_FLOAT  = 20000,
  parameter int T_CALIB      = 525000,
  parameter int T_QUIET      = 35,
  parameter int T_DUMMY_MIN  = 10,
  parameter int T_DUMMY_MAX  = 10000,
  parameter int T_SETTLE     = 700,
  parameter int T_FREE_RUN   = 58000,
  parameter int T_DRIFT      = 3000000,
  parameter int T_WAKE_FLOAT = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic sel_n,
  input  logic sclk,
  input  logic burst_done,
  output logic burst_start,
  output logic rdy_out,
  output logic rdy_oe
);
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXP = imax(imax(imax(T_PWR_FLOAT, T_CALIB), imax(T_QUIET, T_DUMMY_MAX)),
                             imax(imax(T_SETTLE, T_FREE_RUN), imax(T_DRIFT, T_WAKE_FLOAT)));
  localparam int CW = $clog2(MAXP + 2);
  localparam logic [CW-1:0] LIM_PF = CW'(T_PWR_FLOAT - 1);
  localparam logic [CW-1:0] LIM_CA = CW'(T_CALIB - 1);
  localparam logic [CW-1:0] LIM_QT = CW'(T_QUIET - 1);
  localparam logic [CW-1:0] LIM_ST = CW'(T_SETTLE - 1);
  localparam logic [CW-1:0] LIM_FR = CW'(T_FREE_RUN - 1);
  localparam logic [CW-1:0] LIM_DR = CW'(T_DRIFT - 1);
  localparam logic [CW-1:0] LIM_WF = CW'(T_WAKE_FLOAT - 1);
  localparam logic [CW-1:0] DW_LO  = CW'(T_DUMMY_MIN);
  localparam logic [CW-1:0] DW_HI  = CW'(T_DUMMY_MAX);

  // Synchronised inputs: bit 1 select, bit 0 serial clock.
  logic [1:0] s_lvl, s_rise, s_fall;
  tsbs_sync #(.N(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({sel_n, sclk}),
    .lvl (s_lvl),
    .rise(s_rise),
    .fall(s_fall)
  );
  logic cs_hi, cs_rise, cs_fall, ck_rise;
  assign cs_hi   = s_lvl[1];
  assign cs_rise = s_rise[1];
  assign cs_fall = s_fall[1];
  assign ck_rise = s_rise[0];

  seq_state_t st_q, st_nx;
  logic go_q, go_nx, clr_evt, tmr_clr;
  logic [CW-1:0] cnt;

  assign tmr_clr = clr_evt || (st_nx != st_q);

  tsbs_timer #(.W(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(tick_us),
    .clr (tmr_clr),
    .cnt (cnt)
  );

  always_comb begin
    st_nx   = st_q;
    go_nx   = go_q;
    clr_evt = 1'b0;
    unique case (st_q)
      ST_PFLOAT: if (tick_us && cnt == LIM_PF) st_nx = ST_CAL;
      ST_CAL:    if (tick_us && cnt == LIM_CA) st_nx = ST_IDLE;
      ST_IDLE: begin
        clr_evt = !cs_hi;
        if (cs_fall) st_nx = ST_SELECT;
        else if (cs_hi && tick_us && cnt == LIM_FR) st_nx = ST_BURST;
      end
      ST_SELECT: begin
        if (ck_rise) st_nx = ST_TAIL;
        else if (cs_rise) st_nx = (cnt >= DW_LO && cnt <= DW_HI) ? ST_SETTLE : ST_IDLE;
      end
      ST_TAIL: begin
        if (ck_rise) clr_evt = 1'b1;
        else if (tick_us && cnt == LIM_QT) st_nx = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (cs_rise) begin
          st_nx = ST_WAKE;
          go_nx = 1'b1;
        end else if (ck_rise) begin
          st_nx = ST_WAKE;
          go_nx = 1'b0;
        end else if (tick_us && cnt == LIM_DR) begin
          st_nx = ST_WAKE;
          go_nx = 1'b1;
        end
      end
      ST_WAKE: begin
        if (cs_rise) go_nx = 1'b1;
        if (tick_us && cnt == LIM_WF) st_nx = (go_q || cs_rise) ? ST_BURST : ST_TAIL;
      end
      ST_SETTLE: if (tick_us && cnt == LIM_ST) st_nx = ST_BURST;
      ST_BURST:  if (burst_done) st_nx = ST_IDLE;
      default:   st_nx = ST_PFLOAT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_PFLOAT;
      go_q        <= 1'b0;
      burst_start <= 1'b0;
      rdy_oe      <= 1'b0;
      rdy_out     <= 1'b0;
    end else begin
      st_q        <= st_nx;
      go_q        <= go_nx;
      burst_start <= (st_nx == ST_BURST) && (st_q != ST_BURST);
      rdy_oe      <= !(st_nx inside {ST_PFLOAT, ST_WAKE});
      rdy_out     <= st_nx inside {ST_IDLE, ST_SELECT, ST_TAIL, ST_SETTLE};
    end
  end

  assert_start_single_R9: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> !burst_start);
  assert_done_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BURST && burst_done) |=> (rdy_out && rdy_oe));
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> (rdy_oe && !rdy_out));
  assert_sleep_low_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP) |-> (rdy_oe && !rdy_out));
  assert_float_from_sleep_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_oe) |-> ($past(st_q) == ST_SLEEP));
endmodule

// File: tb/tb_touch_burst_seq.sv
module tb_touch_burst_seq;
  localparam int PF = 5, CA = 8, QT = 6, DMIN = 3, DMAX = 12, SETL = 7, FR = 20, DR = 40, WF = 6;
  localparam int M_PF = 0, M_CA = 1, M_ID = 2, M_SE = 3, M_TA = 4, M_SL = 5, M_WK = 6, M_ST = 7, M_BU = 8;

  logic clk = 1'b0, rst = 1'b1, tick_us = 1'b0, sel_n = 1'b1, sclk = 1'b0, burst_done = 1'b0;
  logic burst_start, rdy_out, rdy_oe;

  always #10 clk = ~clk;

  touch_burst_seq #(
    .T_PWR_FLOAT(PF), .T_CALIB(CA), .T_QUIET(QT), .T_DUMMY_MIN(DMIN), .T_DUMMY_MAX(DMAX),
    .T_SETTLE(SETL), .T_FREE_RUN(FR), .T_DRIFT(DR), .T_WAKE_FLOAT(WF)
  ) dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .sel_n(sel_n), .sclk(sclk),
    .burst_done(burst_done), .burst_start(burst_start), .rdy_out(rdy_out), .rdy_oe(rdy_oe)
  );

  int n_cmp = 0, n_bad = 0, n_start = 0, tcnt = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Tick every fourth clock.
  always @(negedge clk) begin
    tcnt++;
    tick_us <= (tcnt % 4 == 0);
  end

  // Behavioural reference model.
  int md = M_PF, mt = 0;
  bit mgo = 0, c1 = 0, c2 = 0, c3 = 0, k1 = 0, k2 = 0, k3 = 0;
  bit e_start = 0, e_rdy = 0, e_oe = 0;

  always @(posedge clk) begin
    int nm;
    bit nclr, ng, up, dn, kup;
    if (rst) begin
      md = M_PF; mt = 0; mgo = 0;
      c1 = 0; c2 = 0; c3 = 0; k1 = 0; k2 = 0; k3 = 0;
      e_start = 0; e_rdy = 0; e_oe = 0;
    end else begin
      up = c2 && !c3; dn = !c2 && c3; kup = k2 && !k3;
      nm = md; nclr = 0; ng = mgo;
      if (md == M_PF) begin
        if (tick_us && mt == PF - 1) nm = M_CA;
      end else if (md == M_CA) begin
        if (tick_us && mt == CA - 1) nm = M_ID;
      end else if (md == M_ID) begin
        nclr = !c2;
        if (dn) nm = M_SE;
        else if (c2 && tick_us && mt == FR - 1) nm = M_BU;
      end else if (md == M_SE) begin
        if (kup) nm = M_TA;
        else if (up) nm = (mt >= DMIN && mt <= DMAX) ? M_ST : M_ID;
      end else if (md == M_TA) begin
        if (kup) nclr = 1;
        else if (tick_us && mt == QT - 1) nm = M_SL;
      end else if (md == M_SL) begin
        if (up) begin nm = M_WK; ng = 1; end
        else if (kup) begin nm = M_WK; ng = 0; end
        else if (tick_us && mt == DR - 1) begin nm = M_WK; ng = 1; end
      end else if (md == M_WK) begin
        if (up) ng = 1;
        if (tick_us && mt == WF - 1) nm = (mgo || up) ? M_BU : M_TA;
      end else if (md == M_ST) begin
        if (tick_us && mt == SETL - 1) nm = M_BU;
      end else begin
        if (burst_done) nm = M_ID;
      end
      e_start = (nm == M_BU) && (md != M_BU);
      if (nm != md || nclr) mt = 0;
      else if (tick_us) mt++;
      md = nm; mgo = ng;
      e_oe  = !(md == M_PF || md == M_WK);
      e_rdy = (md == M_ID || md == M_SE || md == M_TA || md == M_ST);
      c3 = c2; c2 = c1; c1 = sel_n;
      k3 = k2; k2 = k1; k1 = sclk;
    end
  end

  // Burst responder: done pulse five cycles after an expected start.
  int dly = 0;
  always @(negedge clk) begin
    burst_done <= 1'b0;
    if (e_start && !rst) dly = 5;
    else if (dly > 0) begin
      dly--;
      if (dly == 0) burst_done <= 1'b1;
    end
  end

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    string rq;
    if (!rst) begin
      case (md)
        M_PF, M_CA: rq = "R1";
        M_ID:       rq = "R2";
        M_SE:       rq = "R4";
        M_ST:       rq = "R3";
        M_TA, M_SL: rq = "R5";
        M_WK:       rq = "R6";
        default:    rq = "R9";
      endcase
      chk(burst_start == e_start, {rq, " start"}, burst_start, e_start);
      chk(rdy_out == e_rdy, {rq, " rdy"}, rdy_out, e_rdy);
      chk(rdy_oe == e_oe, {rq, " oe"}, rdy_oe, e_oe);
      if (burst_start) begin
        n_start++;
        chk(rdy_oe && !rdy_out, "R10 start while busy", {rdy_oe, rdy_out}, 2);
      end
    end
  end

  task automatic wait_done();
    @(posedge clk);
    while (!burst_done) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic transfer();
    sel_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; repeat (2) @(negedge clk);
      sclk = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(rdy_oe == 1'b0, "R1 reset float", rdy_oe, 0);
    chk(burst_start == 1'b0, "R1 reset start", burst_start, 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    chk(rdy_oe && !rdy_out, "R1 calibration low", {rdy_oe, rdy_out}, 2);
    repeat (40) @(negedge clk);
    chk(rdy_oe && rdy_out, "R1 ready after calibration", {rdy_oe, rdy_out}, 3);

    // Free-running bursts with select held high.
    n_start = 0;
    repeat (250) @(negedge clk);
    chk(n_start >= 2, "R2 free-run bursts", n_start, 2);

    // Accepted dummy pulse.
    wait_done();
    n_start = 0;
    sel_n = 1'b0; repeat (32) @(negedge clk); sel_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(rdy_oe && rdy_out && n_start == 0, "R3 settle held high", n_start, 0);
    repeat (58) @(negedge clk);
    chk(n_start == 1, "R3 dummy burst", n_start, 1);

    // Too short.
    wait_done();
    n_start = 0;
    sel_n = 1'b0; repeat (5) @(negedge clk); sel_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(n_start == 0 && rdy_out, "R4 short pulse ignored", n_start, 0);

    // Too long.
    wait_done();
    n_start = 0;
    sel_n = 1'b0; repeat (72) @(negedge clk); sel_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(n_start == 0 && rdy_out, "R4 long pulse ignored", n_start, 0);

    // Transfer, early select rise ignored, sleep, select wake.
    wait_done();
    n_start = 0;
    transfer();
    repeat (50) @(negedge clk);
    chk(!rdy_out && rdy_oe && n_start == 0, "R5 sleep after quiet", rdy_out, 0);
    sel_n = 1'b0; repeat (8) @(negedge clk); sel_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(rdy_oe == 1'b0, "R6 wake float", rdy_oe, 0);
    repeat (60) @(negedge clk);
    chk(n_start == 1, "R6 burst after wake", n_start, 1);

    // Clock wake without burst, then drift wake.
    wait_done();
    n_start = 0;
    transfer();
    repeat (50) @(negedge clk);
    sclk = 1'b1; repeat (2) @(negedge clk); sclk = 1'b0;
    repeat (6) @(negedge clk);
    chk(rdy_oe == 1'b0, "R7 clock wake float", rdy_oe, 0);
    repeat (24) @(negedge clk);
    chk(rdy_oe && rdy_out && n_start == 0, "R7 awake without burst", n_start, 0);
    repeat (48) @(negedge clk);
    chk(rdy_oe && !rdy_out, "R7 back to sleep", rdy_out, 0);
    repeat (220) @(negedge clk);
    chk(n_start == 1, "R8 drift burst", n_start, 1);

    // Clock wake with select pulse inside the float.
    wait_done();
    n_start = 0;
    transfer();
    repeat (50) @(negedge clk);
    sclk = 1'b1; repeat (2) @(negedge clk); sclk = 1'b0;
    repeat (4) @(negedge clk);
    sel_n = 1'b0; repeat (4) @(negedge clk); sel_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(n_start == 1, "R7 select during float bursts", n_start, 1);
    wait_done();
    chk(rdy_oe && rdy_out, "R9 ready after done", {rdy_oe, rdy_out}, 3);
    repeat (10) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule